// File: doc/BRIEF.md
# Compute-Mode Instruction Sequencer for a Mesh Processing Element

This block is the compute engine of one processing element in a rectangular mesh. While compute mode is selected it walks a program counter through a 128-word control memory. It executes one 40-bit instruction per cycle. Each instruction names up to three source locations and one destination location. Operands come from four independent operand banks that are read combinationally, and the result goes back through a single write port. The arithmetic is a 32-bit two's-complement integer stand-in with add, subtract, multiply, multiply-accumulate and divide. The block also provides a branch-if-negative, a fetch of a neighbour's exchange register selected by a direction field, and a store into the local exchange register, which the four adjacent elements can read.

The control memory and the operand banks are outside the block. The sequencer drives the program address and one read address per bank, and it drives the write-back strobe, location and data. When compute mode is deselected the program counter parks. Each new entry into compute mode restarts the program at address 0. When two sources of one instruction live in the same bank, the reads are spread over extra cycles, one conflicting read per cycle.

The control flow is a three-state machine:
- `ST_PARK` (compute mode off). Park→Issue when `compute_en` is seen high; the PC is cleared on that edge.
- `ST_ISSUE` (first cycle of an instruction). Issue→Issue when all operands are present, so the instruction retires. Issue→Gather on a bank conflict. Issue→Park when `compute_en` is low.
- `ST_GATHER` (extra read cycles). Gather→Gather while reads remain. Gather→Issue on retire. Gather→Park when `compute_en` is low.

Top module: `pe_sequencer`

## Requirements
- R1: An instruction word is laid out as opcode[39:36], source A[35:27], source B[26:18], source C[17:9] and destination[8:0]. Every 9-bit location is {bank[8:7], offset[6:0]}. Opcode values are: 0 add, 1 subtract, 2 multiply, 3 multiply-accumulate, 4 divide, 5 branch-if-negative, 6 neighbour fetch, 7 exchange store, and 8 to 15 no operation.
- R2: Add writes A+B, subtract writes A−B and multiply writes the low 32 bits of A×B to the destination, all in two's complement.
- R3: Multiply-accumulate writes A + B×C. When A, B and C sit in three different banks, the instruction retires in the cycle it is issued.
- R4: Divide writes the signed quotient truncated toward zero. A zero divisor writes 0 and sets `div_fault`, which stays set until reset.
- R5: Each source that names the same bank as an earlier source of the same instruction (A before B before C) adds one cycle before retirement. The written result is the same as with no conflict.
- R6: Branch-if-negative tests source A. When bit 31 is set, the PC is loaded with destination[6:0]; otherwise the PC increments. It never writes operand memory.
- R7: A retiring instruction that is not a taken branch advances the PC by one, and address 127 wraps to 0.
- R8: Neighbour fetch takes the direction from source A[1:0] (0 north, 1 west, 2 south, 3 east) and writes that neighbour's exchange value to the destination. A direction off the mesh edge, as given by the position parameters, writes 0.
- R9: Exchange store loads source A into `xchg_out` on the retiring edge. No other instruction changes `xchg_out`.
- R10: Opcodes 8 to 15 write nothing and advance the PC.
- R11: While `compute_en` is low, the PC holds and no write-back occurs, and an instruction in flight is abandoned. The first cycle with `compute_en` high clears the PC to 0.
- R12: After reset the PC is 0 and the block is parked, with no write strobe, `xchg_out` at 0 and `div_fault` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compute_en | input | 1 | Compute mode select; low parks the sequencer |
| prog_addr | output | OFF_W | Control memory address (the PC) |
| prog_data | input | 4+4·(BANK_W+OFF_W) | Instruction read at `prog_addr` |
| opnd_raddr | output | BANKS×OFF_W | Read offset for each operand bank |
| opnd_rdata | input | BANKS×DATA_W | Combinational read data of each bank |
| wb_en | output | 1 | Write-back strobe, taken at the next rising edge |
| wb_bank | output | BANK_W | Write-back bank |
| wb_off | output | OFF_W | Write-back offset |
| wb_data | output | DATA_W | Write-back value |
| nbr_xchg | input | 4×DATA_W | Exchange values of the neighbours, index 0 north, 1 west, 2 south, 3 east |
| xchg_out | output | DATA_W | Local exchange register, visible to neighbours |
| div_fault | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions assume that `prog_data` and `opnd_rdata` settle within the cycle their addresses are presented. They also assume that a written location becomes readable at the following edge and that `compute_en` changes only between edges. The bench keeps to this by modelling every memory as a combinational array with an edge-triggered write port, and it drives all inputs two nanoseconds after a rising edge. Every program ends in a branch-if-negative that targets itself, so the PC settles at a known address whatever the run length. No divide stimulus uses the one overflowing quotient (most negative value divided by −1), whose result the requirements leave open.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

    localparam int OPC_W   = 4;
    localparam int NUM_SRC = 3;
    localparam int NUM_DIR = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_MUL    = 4'd2,
        OP_MAC    = 4'd3,
        OP_DIV    = 4'd4,
        OP_BRNEG  = 4'd5,
        OP_NBRGET = 4'd6,
        OP_XCHPUT = 4'd7,
        OP_IDLE   = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        DIR_NORTH = 2'd0,
        DIR_WEST  = 2'd1,
        DIR_SOUTH = 2'd2,
        DIR_EAST  = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_GATHER = 2'd2
    } seq_state_e;

    // Which sources an opcode reads: bit0 = A, bit1 = B, bit2 = C.
    function automatic logic [NUM_SRC-1:0] sources_read(input opcode_e op);
        logic [NUM_SRC-1:0] mask;
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: mask = 3'b011;
            OP_MAC:                         mask = 3'b111;
            OP_BRNEG, OP_XCHPUT:            mask = 3'b001;
            default:                        mask = 3'b000;
        endcase
        return mask;
    endfunction

endpackage

// File: rtl/pe_int_alu.sv
module pe_int_alu
    import pe_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] result,
    output logic              div_zero
);

    logic [DATA_W-1:0] product_bc;
    logic [DATA_W-1:0] product_ab;
    logic [DATA_W-1:0] quotient;

    assign product_ab = a * b;
    assign product_bc = b * c;
    assign quotient   = (b == '0) ? '0 : DATA_W'($signed(a) / $signed(b));

    always_comb begin
        div_zero = 1'b0;
        case (op)
            OP_ADD: result = a + b;
            OP_SUB: result = a - b;
            OP_MUL: result = product_ab;
            OP_MAC: result = a + product_bc;
            OP_DIV: begin
                result   = quotient;
                div_zero = (b == '0);
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/pe_nbr_select.sv
module pe_nbr_select
    import pe_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int GRID_ROWS = 4,
    parameter int GRID_COLS = 4,
    parameter int ROW_POS   = 0,
    parameter int COL_POS   = 0
) (
    input  logic [1:0]                      dir,
    input  logic [NUM_DIR-1:0][DATA_W-1:0]  nbr_xchg,
    output logic [DATA_W-1:0]               value
);

    logic [NUM_DIR-1:0][DATA_W-1:0] gated;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam bit PRESENT =
            (d == int'(DIR_NORTH)) ? (ROW_POS > 0) :
            (d == int'(DIR_WEST))  ? (COL_POS > 0) :
            (d == int'(DIR_SOUTH)) ? (ROW_POS < GRID_ROWS - 1) :
                                     (COL_POS < GRID_COLS - 1);
        if (PRESENT) begin : g_link
            assign gated[d] = nbr_xchg[d];
        end else begin : g_edge
            assign gated[d] = '0;
        end
    end

    assign value = gated[dir];

endmodule

// File: rtl/pe_operand_gather.sv
module pe_operand_gather
    import pe_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANKS  = 4,
    parameter int OFF_W  = 7,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              active,
    input  logic                              fresh,
    input  logic [NUM_SRC-1:0]                used,
    input  logic [NUM_SRC-1:0][BANK_W-1:0]    src_bank,
    input  logic [NUM_SRC-1:0][OFF_W-1:0]     src_off,
    input  logic [BANKS-1:0][DATA_W-1:0]      opnd_rdata,
    output logic [BANKS-1:0][OFF_W-1:0]       opnd_raddr,
    output logic [NUM_SRC-1:0][DATA_W-1:0]    src_val,
    output logic                              complete
);

    logic [NUM_SRC-1:0]             have_q;
    logic [NUM_SRC-1:0]             have_eff;
    logic [NUM_SRC-1:0]             need;
    logic [NUM_SRC-1:0]             grant;
    logic [NUM_SRC-1:0][DATA_W-1:0] cap_q;

    // An earlier source wins a shared bank; later ones wait a cycle.
    always_comb begin
        have_eff = fresh ? '0 : have_q;
        need     = used & ~have_eff;
        for (int i = 0; i < NUM_SRC; i++) begin
            grant[i] = need[i];
            for (int j = 0; j < i; j++) begin
                if (need[j] && (src_bank[j] == src_bank[i])) begin
                    grant[i] = 1'b0;
                end
            end
        end
        complete = (((have_eff | grant) & used) == used);
    end

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            opnd_raddr[b] = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (grant[i] && (src_bank[i] == BANK_W'(b))) begin
                    opnd_raddr[b] = src_off[i];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_val[i] = have_eff[i] ? cap_q[i] : opnd_rdata[src_bank[i]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= '0;
            cap_q  <= '0;
        end else if (active && !complete) begin
            have_q <= have_eff | grant;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (grant[i]) begin
                    cap_q[i] <= src_val[i];
                end
            end
        end else begin
            have_q <= '0;
        end
    end

    // R5: with three sources, at most two extra read cycles are ever needed
    a_r5_gather_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fresh && $past(active && !fresh)) |-> complete);

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
    import pe_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BANKS     = 4,
    parameter int OFF_W     = 7,
    parameter int GRID_ROWS = 4,
    parameter int GRID_COLS = 4,
    parameter int ROW_POS   = 0,
    parameter int COL_POS   = 0,
    localparam int BANK_W   = $clog2(BANKS),
    localparam int LOC_W    = BANK_W + OFF_W,
    localparam int INSTR_W  = OPC_W + (NUM_SRC + 1) * LOC_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             compute_en,
    output logic [OFF_W-1:0]                 prog_addr,
    input  logic [INSTR_W-1:0]               prog_data,
    output logic [BANKS-1:0][OFF_W-1:0]      opnd_raddr,
    input  logic [BANKS-1:0][DATA_W-1:0]     opnd_rdata,
    output logic                             wb_en,
    output logic [BANK_W-1:0]                wb_bank,
    output logic [OFF_W-1:0]                 wb_off,
    output logic [DATA_W-1:0]                wb_data,
    input  logic [3:0][DATA_W-1:0]           nbr_xchg,
    output logic [DATA_W-1:0]                xchg_out,
    output logic                             div_fault
);

    seq_state_e state_q;
    seq_state_e state_nx;

    logic [OFF_W-1:0]  pc_q;
    logic [DATA_W-1:0] xchg_q;
    logic              fault_q;

    opcode_e                         op;
    logic [NUM_SRC-1:0][LOC_W-1:0]   src_loc;
    logic [NUM_SRC-1:0][BANK_W-1:0]  src_bank;
    logic [NUM_SRC-1:0][OFF_W-1:0]   src_off;
    logic [LOC_W-1:0]                dst_loc;
    logic [NUM_SRC-1:0]              used;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_val;

    logic              active;
    logic              fresh;
    logic              complete;
    logic              retire;
    logic              take_branch;
    logic              store_fire;
    logic              div_hit;
    logic [DATA_W-1:0] alu_res;
    logic              alu_div_zero;
    logic [DATA_W-1:0] nbr_val;

    // ---------------- instruction fields ----------------
    assign op      = opcode_e'(prog_data[INSTR_W-1 -: OPC_W]);
    assign dst_loc = prog_data[LOC_W-1:0];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        assign src_loc[i]  = prog_data[(NUM_SRC - i) * LOC_W +: LOC_W];
        assign src_bank[i] = src_loc[i][LOC_W-1 -: BANK_W];
        assign src_off[i]  = src_loc[i][OFF_W-1:0];
    end

    assign used   = sources_read(op);
    assign active = compute_en && (state_q != ST_PARK);
    assign fresh  = (state_q == ST_ISSUE);
    assign retire = active && complete;

    // ---------------- sub-blocks ----------------
    pe_operand_gather #(
        .DATA_W (DATA_W),
        .BANKS  (BANKS),
        .OFF_W  (OFF_W)
    ) u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .fresh      (fresh),
        .used       (used),
        .src_bank   (src_bank),
        .src_off    (src_off),
        .opnd_rdata (opnd_rdata),
        .opnd_raddr (opnd_raddr),
        .src_val    (src_val),
        .complete   (complete)
    );

    pe_int_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op       (op),
        .a        (src_val[0]),
        .b        (src_val[1]),
        .c        (src_val[2]),
        .result   (alu_res),
        .div_zero (alu_div_zero)
    );

    pe_nbr_select #(
        .DATA_W    (DATA_W),
        .GRID_ROWS (GRID_ROWS),
        .GRID_COLS (GRID_COLS),
        .ROW_POS   (ROW_POS),
        .COL_POS   (COL_POS)
    ) u_nbr (
        .dir      (src_loc[0][1:0]),
        .nbr_xchg (nbr_xchg),
        .value    (nbr_val)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_PARK: begin
                if (compute_en) state_nx = ST_ISSUE;
            end
            ST_ISSUE, ST_GATHER: begin
                if (!compute_en)   state_nx = ST_PARK;
                else if (complete) state_nx = ST_ISSUE;
                else               state_nx = ST_GATHER;
            end
            default: state_nx = ST_PARK;
        endcase
    end

    // ---------------- outputs of a retiring instruction ----------------
    always_comb begin
        wb_en       = 1'b0;
        wb_data     = alu_res;
        take_branch = 1'b0;
        store_fire  = 1'b0;
        div_hit     = 1'b0;
        if (retire) begin
            case (op)
                OP_ADD, OP_SUB, OP_MUL, OP_MAC: wb_en = 1'b1;
                OP_DIV: begin
                    wb_en   = 1'b1;
                    div_hit = alu_div_zero;
                end
                OP_NBRGET: begin
                    wb_en   = 1'b1;
                    wb_data = nbr_val;
                end
                OP_BRNEG:  take_branch = src_val[0][DATA_W-1];
                OP_XCHPUT: store_fire  = 1'b1;
                default: ;
            endcase
        end
    end

    assign wb_bank = dst_loc[LOC_W-1 -: BANK_W];
    assign wb_off  = dst_loc[OFF_W-1:0];

    // ---------------- PC, exchange register, fault flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            xchg_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            if ((state_q == ST_PARK) && compute_en) begin
                pc_q <= '0;
            end else if (retire) begin
                pc_q <= take_branch ? dst_loc[OFF_W-1:0] : pc_q + OFF_W'(1);
            end
            if (store_fire) xchg_q  <= src_val[0];
            if (div_hit)    fault_q <= 1'b1;
        end
    end

    assign prog_addr = pc_q;
    assign xchg_out  = xchg_q;
    assign div_fault = fault_q;

    // ---------------- assertions ----------------
    a_r11_pc_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !compute_en |=> $stable(prog_addr));

    a_r11_entry_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && compute_en) |=> (prog_addr == '0));

    a_r11_no_write_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !compute_en |-> !wb_en);

    a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch |=> (prog_addr == $past(dst_loc[OFF_W-1:0])));

    a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !take_branch) |=> (prog_addr == $past(prog_addr) + OFF_W'(1)));

    a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        div_fault |=> div_fault);

    a_r9_xchg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !store_fire |=> $stable(xchg_out));

    a_r3_mac_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fresh && used == 3'b111 && src_bank[0] != src_bank[1]
         && src_bank[0] != src_bank[2] && src_bank[1] != src_bank[2]) |-> complete);

endmodule

// File: tb/test_pe_sequencer.sv
module test_pe_sequencer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic compute_en = 1'b0;

    logic [6:0]        prog_addr;
    logic [39:0]       prog_data;
    logic [3:0][6:0]   opnd_raddr;
    logic [3:0][31:0]  opnd_rdata;
    logic              wb_en;
    logic [1:0]        wb_bank;
    logic [6:0]        wb_off;
    logic [31:0]       wb_data;
    logic [3:0][31:0]  nbr_xchg;
    logic [31:0]       xchg_out;
    logic              div_fault;

    logic [39:0] cmem [128];
    logic [31:0] bmem [4][128];

    // host preload port into the bench memories
    logic [1:0]  hw_sel = 2'd0;
    logic [1:0]  hw_b = '0;
    logic [6:0]  hw_o = '0;
    logic [39:0] hw_d = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign prog_data = cmem[prog_addr];
    for (genvar b = 0; b < 4; b++) begin : g_bank
        assign opnd_rdata[b] = bmem[b][opnd_raddr[b]];
    end

    always @(posedge clk) begin
        if (wb_en) bmem[wb_bank][wb_off] <= wb_data;
        if (hw_sel == 2'd1) bmem[hw_b][hw_o] <= hw_d[31:0];
        if (hw_sel == 2'd2) cmem[hw_o] <= hw_d;
    end

    pe_sequencer #(
        .DATA_W(32), .BANKS(4), .OFF_W(7),
        .GRID_ROWS(4), .GRID_COLS(4), .ROW_POS(0), .COL_POS(3)
    ) i_pe_sequencer (
        .clk(clk), .rst_n(rst_n), .compute_en(compute_en),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .opnd_raddr(opnd_raddr), .opnd_rdata(opnd_rdata),
        .wb_en(wb_en), .wb_bank(wb_bank), .wb_off(wb_off), .wb_data(wb_data),
        .nbr_xchg(nbr_xchg), .xchg_out(xchg_out), .div_fault(div_fault)
    );

    // ---------------- helpers ----------------
    function automatic logic [8:0] L(input int bank, input int off);
        return {bank[1:0], off[6:0]};
    endfunction

    function automatic logic [39:0] enc(input int op, input logic [8:0] a,
                                        input logic [8:0] b, input logic [8:0] c,
                                        input logic [8:0] d);
        return {op[3:0], a, b, c, d};
    endfunction

    function automatic logic [39:0] halt_at(input int at);
        return enc(5, L(3, 127), 9'd0, 9'd0, L(0, at));
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bank(input int b, input int o, input logic [31:0] v);
        hw_sel = 2'd1; hw_b = b[1:0]; hw_o = o[6:0]; hw_d = {8'd0, v};
        step(1);
        hw_sel = 2'd0;
    endtask

    task automatic put_instr(input int o, input logic [39:0] v);
        hw_sel = 2'd2; hw_o = o[6:0]; hw_d = v;
        step(1);
        hw_sel = 2'd0;
    endtask

    task automatic do_reset();
        compute_en = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic start_run();
        compute_en = 1'b1;
        step(1);
    endtask

    task automatic stop_run();
        compute_en = 1'b0;
        step(1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        check("R12 pc after reset", 40'(prog_addr), 40'd0);
        check("R12 write strobe after reset", 40'(wb_en), 40'd0);
        check("R12 exchange after reset", 40'(xchg_out), 40'd0);
        check("R12 fault after reset", 40'(div_fault), 40'd0);
    endtask

    task automatic t_arith();
        put_bank(0, 1, 32'd100);
        put_bank(1, 1, -32'sd7);
        put_bank(2, 1, 32'd3);
        put_instr(0, enc(0, L(0, 1), L(1, 1), 9'd0, L(2, 10)));
        put_instr(1, enc(1, L(0, 1), L(1, 1), 9'd0, L(3, 10)));
        put_instr(2, enc(2, L(1, 1), L(2, 1), 9'd0, L(0, 10)));
        put_instr(3, enc(3, L(0, 1), L(1, 1), L(2, 1), L(1, 10)));
        put_instr(4, halt_at(4));
        start_run();
        check("R11 pc cleared on entry", 40'(prog_addr), 40'd0);
        step(1); check("R7 pc after add", 40'(prog_addr), 40'd1);
        step(1); check("R7 pc after sub", 40'(prog_addr), 40'd2);
        step(1); check("R7 pc after mul", 40'(prog_addr), 40'd3);
        step(1); check("R3 mac retires in one cycle", 40'(prog_addr), 40'd4);
        step(2); check("R6 halt holds pc", 40'(prog_addr), 40'd4);
        stop_run();
        check("R1 R2 add result", 40'(bmem[2][10]), 40'd93);
        check("R2 sub result", 40'(bmem[3][10]), 40'd107);
        check("R2 mul result", 40'(bmem[0][10]), 40'(32'hFFFF_FFEB));
        check("R3 mac result", 40'(bmem[1][10]), 40'd79);
    endtask

    task automatic t_bank_conflict();
        put_bank(0, 2, 32'd11);
        put_bank(0, 3, 32'd4);
        put_bank(1, 2, 32'd2);
        put_bank(1, 3, 32'd3);
        put_bank(1, 4, 32'd5);
        put_instr(0, enc(0, L(0, 2), L(0, 3), 9'd0, L(2, 11)));
        put_instr(1, enc(3, L(1, 2), L(1, 3), L(1, 4), L(2, 12)));
        put_instr(2, halt_at(2));
        start_run();
        step(1); check("R5 add with shared bank still waiting", 40'(prog_addr), 40'd0);
        step(1); check("R5 add retires after one stall", 40'(prog_addr), 40'd1);
        step(1); check("R5 mac one bank first stall", 40'(prog_addr), 40'd1);
        step(1); check("R5 mac one bank second stall", 40'(prog_addr), 40'd1);
        step(1); check("R5 mac retires after two stalls", 40'(prog_addr), 40'd2);
        stop_run();
        check("R5 add result with conflict", 40'(bmem[2][11]), 40'd15);
        check("R5 mac result with conflict", 40'(bmem[2][12]), 40'd17);
    endtask

    task automatic t_divide();
        put_bank(0, 5, 32'd20);
        put_bank(1, 5, -32'sd3);
        put_bank(2, 5, 32'd0);
        put_bank(3, 21, 32'd77);
        put_instr(0, enc(4, L(0, 5), L(1, 5), 9'd0, L(3, 20)));
        put_instr(1, enc(4, L(0, 5), L(2, 5), 9'd0, L(3, 21)));
        put_instr(2, enc(0, L(0, 5), L(1, 5), 9'd0, L(3, 22)));
        put_instr(3, halt_at(3));
        start_run();
        step(1); check("R4 no fault on nonzero divisor", 40'(div_fault), 40'd0);
        step(1); check("R4 fault on zero divisor", 40'(div_fault), 40'd1);
        step(2); check("R4 fault sticky", 40'(div_fault), 40'd1);
        stop_run();
        check("R4 quotient truncates", 40'(bmem[3][20]), 40'(32'hFFFF_FFFA));
        check("R4 zero divisor writes zero", 40'(bmem[3][21]), 40'd0);
        check("R2 add after fault", 40'(bmem[3][22]), 40'd17);
    endtask

    task automatic t_branch_wrap();
        put_bank(3, 126, 32'd5);
        put_bank(2, 9, 32'd55);
        put_instr(0, enc(5, L(3, 126), 9'd0, 9'd0, L(2, 9)));
        put_instr(1, enc(5, L(3, 127), 9'd0, 9'd0, L(2, 5)));
        put_instr(5, enc(5, L(3, 127), 9'd0, 9'd0, L(2, 127)));
        put_instr(127, enc(9, L(0, 1), L(1, 1), 9'd0, L(2, 9)));
        start_run();
        step(1); check("R6 positive operand falls through", 40'(prog_addr), 40'd1);
        step(1); check("R6 negative operand branches", 40'(prog_addr), 40'd5);
        step(1); check("R6 branch to top address", 40'(prog_addr), 40'd127);
        step(1); check("R7 R10 idle opcode wraps pc", 40'(prog_addr), 40'd0);
        step(1); check("R7 pc runs on after wrap", 40'(prog_addr), 40'd1);
        stop_run();
        check("R6 R10 no write from branch or idle", 40'(bmem[2][9]), 40'd55);
    endtask

    task automatic t_neighbour();
        nbr_xchg[0] = 32'd111;
        nbr_xchg[1] = 32'd222;
        nbr_xchg[2] = 32'd333;
        nbr_xchg[3] = 32'd444;
        put_bank(0, 31, 32'd99);
        put_bank(0, 33, 32'd99);
        put_bank(1, 30, 32'h1234_ABCD);
        put_instr(0, enc(6, {2'b11, 5'b10100, 2'd1}, 9'd0, 9'd0, L(0, 30)));
        put_instr(1, enc(6, {2'b01, 5'b00011, 2'd0}, 9'd0, 9'd0, L(0, 31)));
        put_instr(2, enc(6, {2'b00, 5'b00000, 2'd2}, 9'd0, 9'd0, L(0, 32)));
        put_instr(3, enc(6, {2'b10, 5'b11111, 2'd3}, 9'd0, 9'd0, L(0, 33)));
        put_instr(4, enc(7, L(1, 30), 9'd0, 9'd0, L(3, 0)));
        put_instr(5, enc(0, L(1, 30), L(2, 1), 9'd0, L(2, 30)));
        put_instr(6, halt_at(6));
        start_run();
        step(4); check("R9 exchange untouched before store", 40'(xchg_out), 40'd0);
        step(1); check("R9 exchange loaded by store", 40'(xchg_out), 40'(32'h1234_ABCD));
        step(1); check("R9 exchange held by other opcode", 40'(xchg_out), 40'(32'h1234_ABCD));
        stop_run();
        check("R8 west neighbour fetched", 40'(bmem[0][30]), 40'd222);
        check("R8 north off edge gives zero", 40'(bmem[0][31]), 40'd0);
        check("R8 south neighbour fetched", 40'(bmem[0][32]), 40'd333);
        check("R8 east off edge gives zero", 40'(bmem[0][33]), 40'd0);
    endtask

    task automatic t_mode_switch();
        put_bank(0, 40, 32'd1);
        put_bank(1, 40, 32'd2);
        for (int k = 40; k < 44; k++) put_bank(2, k, 32'd0);
        for (int k = 0; k < 4; k++) put_instr(k, enc(0, L(0, 40), L(1, 40), 9'd0, L(2, 40 + k)));
        put_instr(4, halt_at(4));
        start_run();
        step(2); check("R7 two adds retired", 40'(prog_addr), 40'd2);
        compute_en = 1'b0;
        step(1); check("R11 pc holds when parked", 40'(prog_addr), 40'd2);
        check("R11 no write strobe when parked", 40'(wb_en), 40'd0);
        step(3); check("R11 pc still held", 40'(prog_addr), 40'd2);
        check("R11 abandoned instruction wrote nothing", 40'(bmem[2][42]), 40'd0);
        check("R11 earlier write kept", 40'(bmem[2][41]), 40'd3);
        start_run();
        check("R11 re-entry restarts at zero", 40'(prog_addr), 40'd0);
        step(1); check("R11 runs again from zero", 40'(prog_addr), 40'd1);
        stop_run();
    endtask

    task automatic t_reset_clears();
        do_reset();
        check("R12 reset clears fault", 40'(div_fault), 40'd0);
        check("R12 reset clears exchange", 40'(xchg_out), 40'd0);
        check("R12 reset clears pc", 40'(prog_addr), 40'd0);
    endtask

    // ---------------- main ----------------
    initial begin
        nbr_xchg = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset_state();
        put_bank(3, 127, 32'hFFFF_FFFF);
        t_arith();
        t_bank_conflict();
        t_divide();
        t_branch_wrap();
        t_neighbour();
        t_mode_switch();
        t_reset_clears();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule